// File: doc/BRIEF.md
# Backup Register Zone Access Filter

A bank of general-purpose backup registers sits behind a 32-bit memory-mapped port. Every access carries a secure bit and a privileged bit. Two programmable boundaries split the bank into three contiguous zones. The lowest zone is reserved for secure initiators. The middle zone is writable by secure initiators and readable by anyone. The top zone is open to all. Two privilege-only bits add a second filter on top of the zones. Control-register bits also guard the configuration registers themselves.

Each request is decided in the cycle it is presented. A read that is allowed returns its data one cycle later. A blocked access returns zero, drops any write and raises a violation flag for one cycle. A read-only register reports how many backup registers are implemented. Boundary writes are clamped so that the zones always stay ordered.

Top module: `bkreg_zone_filter`

## Requirements
- R1: After reset, both boundaries and all control bits are zero and every backup register holds zero. As a result the whole bank behaves as the open zone. `rvalid`, `rdata` and `viol` are low.
- R2: Backup register i (from 0) sits at byte address 0x100 + 4*i. The security configuration register is at 0x20, the privilege configuration register at 0x24 and the depth register at 0x3F0. The depth register reads the register count (NUM_REGS) in bits 7:0.
- R3: A register whose index is below the zone-2 start is in zone 1. Non-secure reads and writes of zone 1 are blocked. Secure accesses are allowed.
- R4: A register whose index is at or above the zone-2 start and below the zone-3 start is in zone 2. Non-secure reads of zone 2 are allowed. Non-secure writes are blocked. Secure reads and writes are allowed.
- R5: A register whose index is at or above the zone-3 start is in zone 3. It may be read and written by secure and non-secure accesses alike.
- R6: The security configuration register holds the zone-2 start in bits 7:0 and the zone-3 start in bits 23:16. A boundary of 0 leaves the zones below it empty.
- R7: On a write to the security configuration register, the zone-2 start is clamped to at most NUM_REGS. The zone-3 start is raised to at least the new zone-2 start and clamped to at most NUM_REGS. The readback shows the clamped values.
- R8: Privilege configuration bit 29 blocks unprivileged accesses to zones 1 and 2. Bit 30 blocks unprivileged accesses to zone 3. Bits 31:29 read back as written, and all other bits read zero.
- R9: The configuration registers (0x20, 0x24, 0x3F0) are written only by accesses that are both secure and privileged. Any other write to them is blocked.
- R10: Security configuration bit 31 blocks non-secure reads of the configuration registers. Privilege configuration bit 31 blocks unprivileged reads of them.
- R11: A blocked access returns `rdata` of zero, leaves all state unchanged and drives `viol` high for exactly the one response cycle. An allowed read drives `rvalid` with its data in the cycle after the request.
- R12: A write to the depth register by an allowed initiator changes nothing and raises no violation. Reads of unmapped or misaligned addresses (addr[1:0] not 0) return zero with no violation, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW (10) | Byte address |
| wdata | input | 32 | Write data |
| sec | input | 1 | Initiator is secure |
| priv | input | 1 | Initiator is privileged |
| rvalid | output | 1 | Read response valid, one cycle after a read request |
| rdata | output | 32 | Read data, zero when blocked |
| viol | output | 1 | One-cycle access-violation pulse |

## Verification
The directed cases place boundaries at ordinary interior values, at zero, at the bank depth and in inverted order. This separates off-by-one errors at each zone edge and errors in the clamp order. Every combination of secure and privileged attributes is applied to each zone with both reads and writes. This shows whether the read-versus-write asymmetry of zone 2 and the two privilege bits are decoded independently. A long random mix of backup, configuration, depth, unmapped and misaligned accesses is checked against a bench model. That mix uncovers state leaking from blocked writes and wrong address decoding.

// File: rtl/bkreg_zone_filter.sv
module bkreg_zone_filter #(
  parameter int NUM_REGS = 32,
  parameter int AW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          sec,
  input  logic          priv,
  output logic          rvalid,
  output logic [31:0]   rdata,
  output logic          viol
);
  localparam int         IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] DEPTH  = 8'(NUM_REGS);
  localparam int         WAW    = AW - 2;
  localparam logic [WAW-1:0] W_SEC  = WAW'(32'h20 >> 2);
  localparam logic [WAW-1:0] W_PRV  = WAW'(32'h24 >> 2);
  localparam logic [WAW-1:0] W_HW   = WAW'(32'h3F0 >> 2);
  localparam logic [WAW-1:0] W_BKP  = WAW'(32'h100 >> 2);
  localparam logic [WAW-1:0] W_END  = WAW'((32'h100 >> 2) + NUM_REGS);

  logic [7:0]  z2_q, z3_q;
  logic        ctl_sec_q;
  logic [2:0]  prv_q;
  logic [NUM_REGS-1:0][31:0] bank;

  wire [WAW-1:0] waddr   = addr[AW-1:2];
  wire           aligned = (addr[1:0] == 2'b00);
  wire           bkp_hit = aligned && (waddr >= W_BKP) && (waddr < W_END);
  wire           sec_hit = aligned && (waddr == W_SEC);
  wire           prv_hit = aligned && (waddr == W_PRV);
  wire           hw_hit  = aligned && (waddr == W_HW);
  wire           ctl_hit = sec_hit || prv_hit || hw_hit;
  wire [WAW-1:0] widx    = waddr - W_BKP;
  wire [7:0]     idx8    = 8'(widx);
  wire [IDX_W-1:0] idx   = idx8[IDX_W-1:0];

  wire in_z1  = idx8 < z2_q;
  wire in_low = idx8 < z3_q;

  wire bkp_sec_ok  = sec || (!in_z1 && (!in_low || !we));
  wire bkp_priv_ok = priv || (in_low ? !prv_q[0] : !prv_q[1]);
  wire ctl_rd_ok   = (sec || !ctl_sec_q) && (priv || !prv_q[2]);
  wire ctl_ok      = we ? (sec && priv) : ctl_rd_ok;

  logic allow;
  always_comb begin
    if (bkp_hit)      allow = bkp_sec_ok && bkp_priv_ok;
    else if (ctl_hit) allow = ctl_ok;
    else              allow = 1'b1;
  end

  wire do_wr = req && we && allow;
  wire do_rd = req && !we && allow;

  wire [7:0] wz2  = (wdata[7:0] > DEPTH) ? DEPTH : wdata[7:0];
  wire [7:0] wz3r = (wdata[23:16] < wz2) ? wz2 : wdata[23:16];
  wire [7:0] wz3  = (wz3r > DEPTH) ? DEPTH : wz3r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z2_q      <= '0;
      z3_q      <= '0;
      ctl_sec_q <= 1'b0;
      prv_q     <= '0;
    end else if (do_wr) begin
      if (sec_hit) begin
        z2_q      <= wz2;
        z3_q      <= wz3;
        ctl_sec_q <= wdata[31];
      end
      if (prv_hit) prv_q <= wdata[31:29];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank <= '0;
    else if (do_wr && bkp_hit) bank[idx] <= wdata;
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bkp_hit)      rd_mux = bank[idx];
    else if (sec_hit) rd_mux = {ctl_sec_q, 7'b0, z3_q, 8'b0, z2_q};
    else if (prv_hit) rd_mux = {prv_q, 29'b0};
    else if (hw_hit)  rd_mux = {24'b0, DEPTH};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      viol   <= 1'b0;
    end else begin
      rvalid <= req && !we;
      rdata  <= do_rd ? rd_mux : '0;
      viol   <= req && !allow;
    end
  end

  AST_ZONE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (z2_q <= z3_q) && (z3_q <= DEPTH)); // R7
  AST_VIOL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (rdata == '0)); // R11
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(req)); // R11
  AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !allow) |=> $stable(bank) && $stable(z2_q) && $stable(z3_q) && $stable(prv_q)); // R11
  AST_CFG_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !(sec && priv)) |=> $stable(z2_q) && $stable(z3_q) && $stable(ctl_sec_q) && $stable(prv_q)); // R9
  AST_NS_Z1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !sec && bkp_hit && (idx8 < z2_q)) |=> viol); // R3
  AST_NS_Z2_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !sec && bkp_hit && (idx8 < z3_q)) |=> viol); // R4
  AST_Z3_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req && priv && bkp_hit && (idx8 >= z3_q)) |=> !viol); // R5
  AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid); // R11
endmodule

// File: tb/tb_bkreg_zone_filter.sv
`timescale 1ns/1ps
module tb_bkreg_zone_filter;
  localparam int N  = 32;
  localparam int AW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, sec = 0, priv = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid, viol;
  logic [31:0] rdata;

  bkreg_zone_filter #(.NUM_REGS(N), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .sec(sec), .priv(priv), .rvalid(rvalid), .rdata(rdata), .viol(viol));

  always #4 clk = ~clk;

  int nvec = 0, nbad = 0;
  bit done = 0;

  int m_z2, m_z3;
  bit m_csec;
  bit [2:0] m_prv;
  logic [31:0] m_bank [N];

  function automatic int bidx(input logic [AW-1:0] a);
    if (a[1:0] != 0) return -1;
    if (a < 10'h100 || a >= 10'(256 + 4*N)) return -1;
    return (int'(a) - 256) / 4;
  endfunction

  function automatic bit is_ctl(input logic [AW-1:0] a);
    return a == 10'h20 || a == 10'h24 || a == 10'h3F0;
  endfunction

  function automatic bit ok(input bit w, input logic [AW-1:0] a, input bit s, input bit p);
    int i;
    i = bidx(a);
    if (i >= 0) begin
      if (i < m_z2) return s && (p || !m_prv[0]);
      if (i < m_z3) return (s || !w) && (p || !m_prv[0]);
      return p || !m_prv[1];
    end
    if (is_ctl(a)) return w ? (s && p) : ((s || !m_csec) && (p || !m_prv[2]));
    return 1;
  endfunction

  function automatic logic [31:0] rval(input logic [AW-1:0] a);
    int i;
    i = bidx(a);
    if (i >= 0) return m_bank[i];
    if (a == 10'h20) return {m_csec, 7'b0, 8'(m_z3), 8'b0, 8'(m_z2)};
    if (a == 10'h24) return {m_prv, 29'b0};
    if (a == 10'h3F0) return 32'(N);
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic acc(input string tag, input bit w, input logic [AW-1:0] a,
                     input logic [31:0] d, input bit s, input bit p);
    bit al;
    logic [31:0] ex;
    int i, t2, t3;
    al = ok(w, a, s, p);
    ex = (!w && al) ? rval(a) : 32'h0;
    req = 1; we = w; addr = a; wdata = d; sec = s; priv = p;
    @(negedge clk);
    req = 0;
    check(tag, "viol", 32'(viol), 32'(!al));
    check(tag, "rvalid", 32'(rvalid), 32'(!w));
    check(tag, "rdata", rdata, ex);
    if (w && al) begin
      i = bidx(a);
      if (i >= 0) m_bank[i] = d;
      else if (a == 10'h20) begin
        t2 = (d[7:0] > N) ? N : int'(d[7:0]);
        t3 = (int'(d[23:16]) < t2) ? t2 : int'(d[23:16]);
        if (t3 > N) t3 = N;
        m_z2 = t2; m_z3 = t3; m_csec = d[31];
      end else if (a == 10'h24) m_prv = d[31:29];
    end
  endtask

  function automatic logic [AW-1:0] badr(input int i);
    return 10'(256 + 4*i);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_z2 = 0; m_z3 = 0; m_csec = 0; m_prv = 0;
    for (int k = 0; k < N; k++) m_bank[k] = 0;
    repeat (3) @(negedge clk);
    check("R1", "reset viol", 32'(viol), 0);
    check("R1", "reset rvalid", 32'(rvalid), 0);
    check("R1", "reset rdata", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    acc("R1", 0, 10'h20, 0, 1, 1);
    acc("R1", 0, 10'h24, 0, 1, 1);
    acc("R1", 0, badr(0), 0, 0, 0);
    acc("R2", 0, 10'h3F0, 0, 0, 0);
    acc("R2", 1, badr(N-1), 32'hCAFE0001, 0, 0);
    acc("R2", 0, badr(N-1), 0, 0, 0);
    for (int k = 0; k < N; k++) acc("R2", 1, badr(k), 32'hA5000000 + k, 1, 1);
    acc("R6", 1, 10'h20, 32'h000A_0004, 1, 1);
    acc("R6", 0, 10'h20, 0, 0, 0);
    acc("R3", 0, badr(3), 0, 0, 1);
    acc("R3", 1, badr(3), 32'h11111111, 0, 1);
    acc("R3", 0, badr(3), 0, 1, 0);
    acc("R3", 1, badr(0), 32'h22222222, 1, 0);
    acc("R4", 0, badr(4), 0, 0, 0);
    acc("R4", 1, badr(9), 32'h33333333, 0, 1);
    acc("R4", 0, badr(9), 0, 1, 1);
    acc("R4", 1, badr(9), 32'h44444444, 1, 0);
    acc("R5", 1, badr(10), 32'h55555555, 0, 0);
    acc("R5", 0, badr(10), 0, 0, 0);
    acc("R7", 1, 10'h20, 32'h0064_00C8, 1, 1);
    acc("R7", 0, 10'h20, 0, 1, 1);
    acc("R7", 1, 10'h20, 32'h0003_000A, 1, 1);
    acc("R7", 0, 10'h20, 0, 1, 1);
    acc("R7", 0, badr(9), 0, 0, 0);
    acc("R6", 1, 10'h20, 32'h0000_0000, 1, 1);
    acc("R6", 1, badr(0), 32'h66666666, 0, 0);
    acc("R6", 1, 10'h20, 32'h0000_0005, 1, 1);
    acc("R6", 0, 10'h20, 0, 1, 1);
    acc("R6", 0, badr(5), 0, 0, 0);
    acc("R8", 1, 10'h24, 32'h4000_0000, 1, 1);
    acc("R8", 0, badr(20), 0, 0, 0);
    acc("R8", 0, badr(20), 0, 0, 1);
    acc("R8", 0, badr(2), 0, 1, 0);
    acc("R8", 1, 10'h24, 32'h2000_0000, 1, 1);
    acc("R8", 0, badr(2), 0, 1, 0);
    acc("R8", 0, badr(20), 0, 0, 0);
    acc("R8", 1, 10'h24, 32'hFFFF_FFFF, 1, 1);
    acc("R8", 0, 10'h24, 0, 1, 1);
    acc("R9", 1, 10'h20, 32'h0008_0008, 1, 0);
    acc("R9", 1, 10'h20, 32'h0008_0008, 0, 1);
    acc("R9", 1, 10'h24, 32'h0, 0, 1);
    acc("R9", 0, 10'h20, 0, 1, 1);
    acc("R10", 0, 10'h3F0, 0, 1, 0);
    acc("R10", 1, 10'h24, 32'h0, 1, 1);
    acc("R10", 1, 10'h20, 32'h8000_0005, 1, 1);
    acc("R10", 0, 10'h20, 0, 0, 1);
    acc("R10", 0, 10'h3F0, 0, 0, 1);
    acc("R10", 0, 10'h20, 0, 1, 0);
    acc("R11", 1, badr(1), 32'h77777777, 0, 1);
    acc("R11", 0, badr(1), 0, 1, 1);
    acc("R12", 1, 10'h3F0, 32'hFF, 1, 1);
    acc("R12", 0, 10'h3F0, 0, 1, 1);
    acc("R12", 0, 10'h200, 0, 0, 0);
    acc("R12", 1, badr(12) | 10'h1, 32'h88888888, 1, 1);
    acc("R12", 0, badr(12) | 10'h2, 0, 1, 1);
    acc("R12", 0, badr(12), 0, 1, 1);
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      int sel;
      sel = int'($urandom % 16);
      d = $urandom;
      if (sel < 11)       a = badr(int'($urandom % N));
      else if (sel == 11) a = 10'h20;
      else if (sel == 12) a = 10'h24;
      else if (sel == 13) a = 10'h3F0;
      else                a = 10'($urandom);
      if (a == 10'h20) d[23:16] = 8'($urandom % 40);
      if (a == 10'h20) d[7:0]   = 8'($urandom % 40);
      if (a == 10'h24 || a == 10'h20) d[31] = ($urandom % 4) == 0;
      acc("R11", 1'($urandom), a, d, 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule